// File: doc/BRIEF.md
# Coin-Accumulating Vend Controller

This block controls a dispenser that takes two coin values, a nickel (5 cents) and a dime (10 cents), and releases one item once the paid credit reaches 15 cents. Each coin arrives as a one-cycle strobe on its own input. The controller keeps the running credit in a small state register. It raises a release output when the price is met. Over-payment is kept and no change is given.

In the default build, the release output is a combinational function of the current credit and the coin strobes. It is high in the same cycle as the coin that completes the price, and the credit returns to zero at the next clock edge. A parameter selects a second build with an extra "paid" state. In that build the release output comes from the register alone: it is high for exactly one cycle, one cycle after the paying coin.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) sets the credit to 0 cents, and the release output is low in the first idle cycle after reset.
- R2: In a cycle with no coin strobe, the credit is kept and the release output is low.
- R3: At 0 cents, a nickel moves the credit to 5 cents and a dime moves it to 10 cents. The release output stays low in both cases. The credit register uses the codes 00 = 0, 01 = 5 and 10 = 10 cents. In the default build the code 11 is never held; if it is ever reached, the next state is 0 cents.
- R4: At 5 cents, a nickel moves the credit to 10 cents with no release. A dime releases the item and returns the credit to 0 cents.
- R5: At 10 cents, either coin releases the item and returns the credit to 0 cents.
- R6: When both strobes are high in the same cycle, the coin is treated as a dime.
- R7: In the default build (`MOORE_BUILD` = 0), the release output is high during the cycle in which the paying coin strobe is present, and low in every other cycle.
- R8: Over-payment (a dime at 10 cents) is absorbed: after it, the credit is 0 cents and no change is given.
- R9: In the alternative build (`MOORE_BUILD` = 1), the paying coin moves the machine to a paid state, code 11. In that state the release output is high for exactly one cycle, and coins that arrive in that cycle are ignored. The machine then returns to 0 cents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_nickel | input | 1 | One-cycle strobe: a 5-cent coin was accepted |
| coin_dime | input | 1 | One-cycle strobe: a 10-cent coin was accepted |
| vend_open | output | 1 | Release one item |

## Verification
A wrong credit value has no effect on the port while coins are absent. It shows up at the next coin that should or should not complete the price: the release output is high in the wrong cycle, or missing where it was due. To catch such an error within a coin or two, the bench compares the output on every cycle against a credit model, and it walks each credit value through both coin types. In the paid-state build, a stuck paid state shows as a release output that stays high for a second cycle. Coins sent during the release cycle show whether they leak into the credit.

// File: rtl/vend_pkg.sv
package vend_pkg;

   localparam int STATE_W      = 2;
   localparam int UNIT_W       = 3;
   localparam int NICKEL_UNITS = 1;
   localparam int DIME_UNITS   = 2;
   localparam int PRICE_UNITS  = 3;

   typedef enum logic [STATE_W-1:0] {
      CR_0    = 2'b00,
      CR_5    = 2'b01,
      CR_10   = 2'b10,
      CR_PAID = 2'b11
   } credit_e;

   typedef enum logic [1:0] {
      COIN_NONE   = 2'b00,
      COIN_NICKEL = 2'b01,
      COIN_DIME   = 2'b10
   } coin_e;

   function automatic logic [UNIT_W-1:0] credit_units(input credit_e c);
      case (c)
         CR_5:    credit_units = UNIT_W'(NICKEL_UNITS);
         CR_10:   credit_units = UNIT_W'(DIME_UNITS);
         default: credit_units = '0;
      endcase
   endfunction

   function automatic logic [UNIT_W-1:0] coin_units(input coin_e k);
      case (k)
         COIN_NICKEL: coin_units = UNIT_W'(NICKEL_UNITS);
         COIN_DIME:   coin_units = UNIT_W'(DIME_UNITS);
         default:     coin_units = '0;
      endcase
   endfunction

   function automatic credit_e units_to_credit(input logic [UNIT_W-1:0] u);
      case (u)
         UNIT_W'(NICKEL_UNITS): units_to_credit = CR_5;
         UNIT_W'(DIME_UNITS):   units_to_credit = CR_10;
         default:               units_to_credit = CR_0;
      endcase
   endfunction

endpackage

// File: rtl/vend_coin_sel.sv
module vend_coin_sel
   import vend_pkg::*;
(
   input  logic  nickel_i,
   input  logic  dime_i,
   output coin_e coin_o
);
   // R6: dime wins when both strobes arrive together
   always_comb begin
      if (dime_i)
         coin_o = COIN_DIME;
      else if (nickel_i)
         coin_o = COIN_NICKEL;
      else
         coin_o = COIN_NONE;
   end
endmodule

// File: rtl/vend_credit_step.sv
module vend_credit_step
   import vend_pkg::*;
#(
   parameter int MOORE_BUILD = 0
) (
   input  credit_e cur_i,
   input  coin_e   coin_i,
   output credit_e nxt_o,
   output logic    pay_o
);
   logic [UNIT_W-1:0] sum;

   if (MOORE_BUILD != 0 && MOORE_BUILD != 1) begin : g_bad_param
      $error("vend_credit_step: MOORE_BUILD must be 0 or 1");
   end

   assign sum = credit_units(cur_i) + coin_units(coin_i);

   always_comb begin
      pay_o = 1'b0;
      nxt_o = cur_i;
      if (cur_i == CR_PAID) begin
         // paid state (alternative build) or unused code (default): back to zero
         nxt_o = CR_0;
      end else if (coin_i != COIN_NONE) begin
         if (sum >= UNIT_W'(PRICE_UNITS)) begin
            pay_o = 1'b1;
            nxt_o = (MOORE_BUILD == 1) ? CR_PAID : CR_0;
         end else begin
            nxt_o = units_to_credit(sum);
         end
      end
   end
endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
   import vend_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  credit_e nxt_i,
   output credit_e cur_o
);
   always_ff @(posedge clk) begin
      if (rst)
         cur_o <= CR_0;
      else
         cur_o <= nxt_i;
   end

   a_r1_reset_zero: assert property (@(posedge clk) rst |=> cur_o == CR_0)
      else $error("R1: credit not cleared by reset");
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
   import vend_pkg::*;
#(
   parameter int MOORE_BUILD = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic coin_nickel,
   input  logic coin_dime,
   output logic vend_open
);
   coin_e   coin;
   credit_e cur_st;
   credit_e nxt_st;
   logic    pay;

   vend_coin_sel u_sel (
      .nickel_i (coin_nickel),
      .dime_i   (coin_dime),
      .coin_o   (coin)
   );

   vend_credit_step #(.MOORE_BUILD(MOORE_BUILD)) u_step (
      .cur_i  (cur_st),
      .coin_i (coin),
      .nxt_o  (nxt_st),
      .pay_o  (pay)
   );

   vend_state_reg u_reg (
      .clk   (clk),
      .rst   (rst),
      .nxt_i (nxt_st),
      .cur_o (cur_st)
   );

   if (MOORE_BUILD == 0) begin : g_mealy
      assign vend_open = pay;

      a_r7_open_needs_coin: assert property (@(posedge clk) disable iff (rst)
         vend_open |-> (coin_nickel || coin_dime))
         else $error("R7: release without coin");
      a_r5_open_clears: assert property (@(posedge clk) disable iff (rst)
         vend_open |=> cur_st == CR_0)
         else $error("R5: credit not cleared after release");
      a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
         (!coin_nickel && !coin_dime) |=> $stable(cur_st))
         else $error("R2: credit moved without coin");
      a_r3_no_unused_code: assert property (@(posedge clk) disable iff (rst)
         cur_st != CR_PAID)
         else $error("R3: unused state code held");
   end else begin : g_moore
      assign vend_open = (cur_st == CR_PAID);

      a_r9_paid_one_cycle: assert property (@(posedge clk) disable iff (rst)
         (cur_st == CR_PAID) |=> cur_st == CR_0)
         else $error("R9: paid state held longer than one cycle");
      a_r9_paid_after_coin: assert property (@(posedge clk) disable iff (rst)
         (cur_st != CR_PAID && (coin_nickel || coin_dime) && cur_st == CR_10)
         |=> vend_open)
         else $error("R9: paying coin did not release");
   end
endmodule

// File: tb/vend_ctrl_tb.sv
`timescale 1ns/1ps
module vend_ctrl_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic n = 1'b0;
   logic d = 1'b0;
   logic open_mealy, open_moore;
   int checks = 0;
   int errors = 0;
   int credit_a = 0;
   int credit_b = 0;
   bit paid_b = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   vend_ctrl #(.MOORE_BUILD(0)) u_dut (
      .clk(clk), .rst(rst), .coin_nickel(n), .coin_dime(d), .vend_open(open_mealy));
   vend_ctrl #(.MOORE_BUILD(1)) u_dut_moore (
      .clk(clk), .rst(rst), .coin_nickel(n), .coin_dime(d), .vend_open(open_moore));

   function automatic int val(input bit nn, input bit dd);
      return dd ? 10 : (nn ? 5 : 0);
   endfunction

   // one cycle: drive at negedge, compare both builds, update the model
   task automatic step(input bit nn, input bit dd, input string req);
      bit exp_a, exp_b;
      int v;
      n = nn; d = dd;
      #1;
      v = val(nn, dd);
      exp_a = (v != 0) && (credit_a + v >= 15);
      exp_b = paid_b;
      checks++;
      if (open_mealy !== exp_a) begin
         errors++;
         $display("FAIL %s default build: vend_open=%b expected %b (credit %0d)", req, open_mealy, exp_a, credit_a);
      end
      checks++;
      if (open_moore !== exp_b) begin
         errors++;
         $display("FAIL %s paid-state build: vend_open=%b expected %b (credit %0d)", req, open_moore, exp_b, credit_b);
      end
      @(posedge clk);
      credit_a = exp_a ? 0 : credit_a + v;
      if (paid_b) begin
         paid_b = 0; credit_b = 0;
      end else if (v != 0 && credit_b + v >= 15) begin
         paid_b = 1; credit_b = 0;
      end else begin
         credit_b = credit_b + v;
      end
      @(negedge clk);
      n = 0; d = 0;
   endtask

   task automatic t_reset();
      rst = 1;
      @(negedge clk); @(negedge clk);
      rst = 0;
      credit_a = 0; credit_b = 0; paid_b = 0;
      step(0, 0, "R1");
      step(1, 0, "R1");
      step(1, 0, "R1");
      step(1, 0, "R1");
      step(0, 0, "R1");
   endtask

   task automatic t_idle();
      step(1, 0, "R2");
      for (int i = 0; i < 4; i++) step(0, 0, "R2");
      step(1, 0, "R2");
      step(0, 0, "R2");
      step(1, 0, "R2");
      step(0, 0, "R2");
   endtask

   task automatic t_from_zero();
      step(1, 0, "R3"); step(1, 0, "R3"); step(1, 0, "R3"); step(0, 0, "R3");
      step(0, 1, "R3"); step(1, 0, "R3"); step(0, 0, "R3");
   endtask

   task automatic t_from_five();
      step(1, 0, "R4"); step(1, 0, "R4"); step(1, 0, "R4"); step(0, 0, "R4");
      step(1, 0, "R4"); step(0, 1, "R4"); step(0, 0, "R4");
   endtask

   task automatic t_from_ten();
      step(0, 1, "R5"); step(1, 0, "R5"); step(0, 0, "R5");
      step(1, 0, "R5"); step(1, 0, "R5"); step(1, 0, "R5"); step(0, 0, "R5");
   endtask

   task automatic t_both();
      step(1, 1, "R6"); step(1, 0, "R6"); step(0, 0, "R6");
      step(1, 0, "R6"); step(1, 1, "R6"); step(0, 0, "R6");
   endtask

   task automatic t_back_to_back();
      // R7: release only in the paying cycle, even with coins every cycle
      for (int i = 0; i < 9; i++) step(1, 0, "R7");
      for (int i = 0; i < 6; i++) step(0, 1, "R7");
      step(0, 0, "R7");
   endtask

   task automatic t_overpay();
      step(0, 1, "R8"); step(0, 1, "R8"); step(0, 0, "R8");
      step(1, 0, "R8"); step(1, 0, "R8"); step(0, 0, "R8");
   endtask

   task automatic t_paid_state();
      // R9: coins in the release cycle of the paid-state build are dropped
      step(0, 1, "R9"); step(0, 1, "R9"); step(0, 1, "R9"); step(1, 0, "R9");
      step(0, 0, "R9"); step(0, 0, "R9");
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_idle();
            t_from_zero();
            t_from_five();
            t_from_ten();
            t_both();
            t_back_to_back();
            t_overpay();
            t_paid_state();
            t_reset();
            done = 1;
         end
         begin
            repeat (5000) @(posedge clk);
            if (!done) begin
               checks++; errors++;
               $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            end
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule